// File: doc/BRIEF.md
# Vector Element Bit-Reverse and Count Unit

This unit handles one element of a vector datapath per cycle. Each element arrives in a 64-bit lane along with three controls. A run-time width select chooses 8, 16, 32 or 64 active bits, a function code picks one of six bit operations, and a per-element enable decides whether the lane is written. The six operations are three reversals and three counts. The reversals swap bit order inside each byte, swap byte order, or reverse the whole element. The counts give leading zeros, trailing zeros or set bits. Every operation works only on the active width. Lane bits above that width are discarded on the way in, and the result is zero-filled above it on the way out.

One register stage sits between the inputs and the outputs. A request sampled on a rising edge shows its result after that edge, together with a one-cycle valid pulse. If the enable is low, the valid pulse is still issued but the lane keeps its old contents. This lets a sequencer step through masked-off elements at full rate.

Top module: `ebr_unit`

## Requirements
- R1: The width select codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 active bits. Operand bits at or above the active width have no effect on the result, and result bits at or above the active width are zero.
- R2: Function code 0 reverses the bit order within each byte of the element and leaves every byte in its position.
- R3: Function code 1 reverses the byte order within the active width. An 8-bit element comes back unchanged.
- R4: Function code 2 reverses the order of all bits within the active width. It is the same as code 0 followed by code 1.
- R5: Function code 3 returns the number of zero bits above the highest set bit of the active width. It returns the width itself for an all-zero element.
- R6: Function code 4 returns the number of zero bits below the lowest set bit. It returns the width itself for an all-zero element.
- R7: Function code 5 returns the number of set bits inside the active width. A count result never exceeds the width.
- R8: Function codes 6 and 7 return zero.
- R9: `out_valid` is high in the cycle after each rising edge at which `in_valid` was high, and low otherwise. The result of an enabled request is visible in that same cycle.
- R10: A request with `in_mask_en` low still produces the `out_valid` pulse, but `out_result` keeps its previous value. `out_result` also holds while `in_valid` is low.
- R11: While `rst_n` is low, `out_valid` and `out_result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_mask_en | input | 1 | Write the lane for this request |
| in_width | input | 2 | Active width select: 0=8, 1=16, 2=32, 3=64 bits |
| in_op | input | 3 | Function code (0..5 defined) |
| in_elem | input | 64 | Element operand, low-aligned in the lane |
| out_valid | output | 1 | One-cycle pulse per request |
| out_result | output | 64 | Zero-extended result lane |

## Verification
The vectors pair narrow widths with non-zero bits above the active field. A unit that fails to discard those bits would return counts above the width, or reversals with stray upper bytes. All-zero elements are tested at several widths, because a leading-zero count taken over the full lane would return 64 instead of 8, 16 or 32. Byte reversal is tested at every width, which exposes a swap stage gated by the wrong threshold. Directed steps check three more things: a masked request still pulses valid while the lane holds its value, an idle cycle drops valid, and a reset in mid-stream clears a non-zero result.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    parameter int unsigned LANE_W = 64;
    localparam int unsigned NBYTE  = LANE_W / 8;
    localparam int unsigned NSTG   = $clog2(NBYTE);
    localparam int unsigned CNT_W  = $clog2(LANE_W) + 1;
    localparam int unsigned WSEL_W = 2;

    typedef enum logic [2:0] {
        OP_BREV8 = 3'd0,
        OP_REV8  = 3'd1,
        OP_BREV  = 3'd2,
        OP_CLZ   = 3'd3,
        OP_CTZ   = 3'd4,
        OP_CPOP  = 3'd5
    } ebr_op_e;

    typedef struct packed {
        logic              vld;
        logic [LANE_W-1:0] res;
    } ebr_state_t;

    // number of active bits for a width select code
    function automatic int unsigned ebr_bits(input logic [WSEL_W-1:0] wsel);
        return 32'd8 << wsel;
    endfunction

endpackage

// File: rtl/ebr_operand_mask.sv
module ebr_operand_mask
    import ebr_pkg::*;
(
    input  logic [LANE_W-1:0] elem_i,
    input  logic [WSEL_W-1:0] wsel_i,
    output logic [LANE_W-1:0] elem_o
);
    // a byte survives when its index is below the active byte count
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        logic keep;
        assign keep = (b < (1 << wsel_i));
        assign elem_o[b*8 +: 8] = keep ? elem_i[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/ebr_bit_flip.sv
module ebr_bit_flip
    import ebr_pkg::*;
(
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[b*8 + i] = din[b*8 + 7 - i];
        end
    end
endmodule

// File: rtl/ebr_byte_swap.sv
module ebr_byte_swap
    import ebr_pkg::*;
(
    input  logic [LANE_W-1:0] din,
    input  logic [WSEL_W-1:0] wsel_i,
    output logic [LANE_W-1:0] dout
);
    logic [LANE_W-1:0] stg [NSTG+1];

    assign stg[0] = din;

    // stage k swaps neighbouring blocks of 8<<k bits when width code > k
    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        localparam int unsigned BLK = 8 << k;
        logic [LANE_W-1:0] swp;
        for (genvar j = 0; j < LANE_W / (2 * BLK); j++) begin : g_pair
            assign swp[j*2*BLK       +: BLK] = stg[k][j*2*BLK + BLK +: BLK];
            assign swp[j*2*BLK + BLK +: BLK] = stg[k][j*2*BLK       +: BLK];
        end
        assign stg[k+1] = (int'(wsel_i) > k) ? swp : stg[k];
    end

    assign dout = stg[NSTG];
endmodule

// File: rtl/ebr_count.sv
module ebr_count
    import ebr_pkg::*;
(
    input  logic [LANE_W-1:0] elem_i,
    input  logic [WSEL_W-1:0] wsel_i,
    output logic [CNT_W-1:0]  clz_o,
    output logic [CNT_W-1:0]  ctz_o,
    output logic [CNT_W-1:0]  pop_o
);
    int unsigned ebits;
    int unsigned lz_full;
    int unsigned tz_full;
    int unsigned pop_cnt;
    logic        hit_hi;
    logic        hit_lo;

    always_comb begin
        ebits   = ebr_bits(wsel_i);
        lz_full = LANE_W;
        tz_full = LANE_W;
        pop_cnt = 0;
        hit_hi  = 1'b0;
        hit_lo  = 1'b0;
        for (int i = LANE_W - 1; i >= 0; i--) begin
            if (!hit_hi && elem_i[i]) begin
                lz_full = LANE_W - 1 - i;
                hit_hi  = 1'b1;
            end
        end
        for (int i = 0; i < LANE_W; i++) begin
            if (!hit_lo && elem_i[i]) begin
                tz_full = i;
                hit_lo  = 1'b1;
            end
            pop_cnt = pop_cnt + {31'd0, elem_i[i]};
        end
        // operand is already cleared above the width, so the lane-wide
        // leading count overshoots by exactly the unused bits
        clz_o = CNT_W'(lz_full - (LANE_W - ebits));
        ctz_o = CNT_W'((tz_full > ebits) ? ebits : tz_full);
        pop_o = CNT_W'(pop_cnt);
    end
endmodule

// File: rtl/ebr_unit.sv
module ebr_unit
    import ebr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mask_en,
    input  logic [1:0]        in_width,
    input  logic [2:0]        in_op,
    input  logic [63:0]       in_elem,
    output logic              out_valid,
    output logic [63:0]       out_result
);
    localparam int unsigned PAD_W = LANE_W - CNT_W;

    logic [LANE_W-1:0] elem_m;
    logic [LANE_W-1:0] brev8_v;
    logic [LANE_W-1:0] rev8_v;
    logic [LANE_W-1:0] brev_v;
    logic [CNT_W-1:0]  clz_v;
    logic [CNT_W-1:0]  ctz_v;
    logic [CNT_W-1:0]  pop_v;
    logic [LANE_W-1:0] fn_v;

    ebr_state_t st_d, st_q;

    ebr_operand_mask i_mask (
        .elem_i (in_elem),
        .wsel_i (in_width),
        .elem_o (elem_m)
    );

    ebr_bit_flip i_flip (
        .din  (elem_m),
        .dout (brev8_v)
    );

    ebr_byte_swap i_swap_plain (
        .din    (elem_m),
        .wsel_i (in_width),
        .dout   (rev8_v)
    );

    ebr_byte_swap i_swap_flipped (
        .din    (brev8_v),
        .wsel_i (in_width),
        .dout   (brev_v)
    );

    ebr_count i_count (
        .elem_i (elem_m),
        .wsel_i (in_width),
        .clz_o  (clz_v),
        .ctz_o  (ctz_v),
        .pop_o  (pop_v)
    );

    always_comb begin
        unique case (in_op)
            OP_BREV8: fn_v = brev8_v;
            OP_REV8:  fn_v = rev8_v;
            OP_BREV:  fn_v = brev_v;
            OP_CLZ:   fn_v = {{PAD_W{1'b0}}, clz_v};
            OP_CTZ:   fn_v = {{PAD_W{1'b0}}, ctz_v};
            OP_CPOP:  fn_v = {{PAD_W{1'b0}}, pop_v};
            default:  fn_v = '0;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid && in_mask_en) begin
            st_d.res = fn_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/ebr_unit_chk.sv
module ebr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_mask_en,
    input logic [1:0]  in_width,
    input logic [2:0]  in_op,
    input logic        out_valid,
    input logic [63:0] out_result
);
    logic [7:0] chk_bits;
    logic       chk_wr;
    logic       chk_cnt;
    logic       chk_bad;

    always_comb begin
        chk_bits = 8'd8 << in_width;
        chk_wr   = in_valid && in_mask_en;
        chk_cnt  = chk_wr && (in_op >= 3'd3) && (in_op <= 3'd5);
        chk_bad  = chk_wr && (in_op >= 3'd6);
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid pulse missing"); // R9
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mask_en) |=> $stable(out_result)) else $error("masked lane changed"); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)) else $error("idle lane changed"); // R10
    AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_wr |=> ((out_result >> $past(chk_bits)) == 64'd0)) else $error("bits above width"); // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_cnt |=> (out_result <= {56'd0, $past(chk_bits)})) else $error("count above width"); // R7
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_bad |=> (out_result == 64'd0)) else $error("undefined code nonzero"); // R8
endmodule

bind ebr_unit ebr_unit_chk i_ebr_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mask_en (in_mask_en),
    .in_width   (in_width),
    .in_op      (in_op),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_ebr_unit.sv
module test_ebr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_mask_en;
    logic [1:0]  in_width;
    logic [2:0]  in_op;
    logic [63:0] in_elem;
    logic        out_valid;
    logic [63:0] out_result;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ebr_unit i_ebr_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mask_en (in_mask_en),
        .in_width   (in_width),
        .in_op      (in_op),
        .in_elem    (in_elem),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  w;
        logic [63:0] elem;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd3, 64'h0123456789ABCDEF, 64'h80C4A2E691D5B3F7, 4'd2},  // R2
        '{3'd0, 2'd0, 64'hFFFFFFFFFFFFFF01, 64'h0000000000000080, 4'd1},  // R1
        '{3'd1, 2'd1, 64'hAAAAAAAAAAAA1234, 64'h0000000000003412, 4'd3},  // R3
        '{3'd1, 2'd2, 64'hDEADBEEF12345678, 64'h0000000078563412, 4'd3},  // R3
        '{3'd1, 2'd3, 64'h0123456789ABCDEF, 64'hEFCDAB8967452301, 4'd3},  // R3
        '{3'd1, 2'd0, 64'h00000000000000AB, 64'h00000000000000AB, 4'd3},  // R3
        '{3'd2, 2'd3, 64'h0000000000000001, 64'h8000000000000000, 4'd4},  // R4
        '{3'd2, 2'd1, 64'hFFFFFFFFFFFF0001, 64'h0000000000008000, 4'd4},  // R4
        '{3'd2, 2'd2, 64'h0000000012345678, 64'h000000001E6A2C48, 4'd4},  // R4
        '{3'd3, 2'd3, 64'h0000000000000000, 64'd64,               4'd5},  // R5
        '{3'd3, 2'd0, 64'hFFFFFFFFFFFFFF01, 64'd7,                4'd5},  // R5
        '{3'd3, 2'd2, 64'h0000000000010000, 64'd15,               4'd5},  // R5
        '{3'd3, 2'd1, 64'hFFFFFFFFFFFF0000, 64'd16,               4'd5},  // R5
        '{3'd4, 2'd3, 64'h8000000000000000, 64'd63,               4'd6},  // R6
        '{3'd4, 2'd2, 64'hFFFFFFFF00000000, 64'd32,               4'd6},  // R6
        '{3'd4, 2'd1, 64'h0000000000000100, 64'd8,                4'd6},  // R6
        '{3'd4, 2'd0, 64'h0000000000000000, 64'd8,                4'd6},  // R6
        '{3'd5, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'd64,               4'd7},  // R7
        '{3'd5, 2'd0, 64'hFFFFFFFFFFFFFFFF, 64'd8,                4'd7},  // R7
        '{3'd5, 2'd2, 64'hF0F0F0F00F0F0F0F, 64'd16,               4'd7},  // R7
        '{3'd5, 2'd1, 64'h0000000000001234, 64'd5,                4'd7},  // R7
        '{3'd6, 2'd3, 64'h0123456789ABCDEF, 64'd0,                4'd8},  // R8
        '{3'd7, 2'd0, 64'h00000000000000FF, 64'd0,                4'd8}   // R8
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // drive at a falling edge, sample after the next rising edge
    task automatic issue(input logic [2:0] op, input logic [1:0] w,
                         input logic [63:0] elem, input logic en);
        in_valid   = 1'b1;
        in_mask_en = en;
        in_op      = op;
        in_width   = w;
        in_elem    = elem;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_mask_en = 1'b0;
        in_width = 2'd0; in_op = 3'd0; in_elem = '0;
        repeat (3) @(negedge clk);
        check("R11 valid at reset", {63'd0, out_valid}, 64'd0);
        check("R11 result at reset", out_result, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].w, VECS[i].elem, 1'b1);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), out_result, VECS[i].exp);
            check("R9 valid pulse", {63'd0, out_valid}, 64'd1);
        end

        // R9: valid drops after an idle cycle, result holds (R10)
        issue(3'd5, 2'd3, 64'h00000000000000FF, 1'b1);
        held = out_result;
        check("R7 popcount", held, 64'd8);
        @(negedge clk);
        check("R9 idle valid", {63'd0, out_valid}, 64'd0);
        check("R10 idle hold", out_result, held);

        // R10: masked request pulses valid but keeps the lane
        issue(3'd2, 2'd3, 64'h0000000000000001, 1'b0);
        check("R10 masked valid", {63'd0, out_valid}, 64'd1);
        check("R10 masked hold", out_result, held);

        // R1: same bits, different width, only the low field counts
        issue(3'd3, 2'd1, 64'h0000000100000080, 1'b1);
        check("R1 clz width16", out_result, 64'd8);

        // R11: reset mid-stream clears a nonzero result
        issue(3'd1, 2'd3, 64'h0123456789ABCDEF, 1'b1);
        check("R3 rev8 before reset", out_result, 64'hEFCDAB8967452301);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 result cleared", out_result, 64'd0);
        check("R11 valid cleared", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule